// File: doc/BRIEF.md
# Snapshot-Read 64-bit Tick Counter

This block keeps a 64-bit count that goes up by one on every cycle in which a count-enable strobe is high. In the target system that strobe comes from a 24 MHz time base, so the count serves as a monotonic timestamp that never stops and, for practical purposes, never wraps. The live count cannot be read directly. Software asks for a snapshot by writing a request bit in the control word. The block then copies the whole 64-bit value into a shadow register in one edge and clears the request bit by itself.

Software polls the request bit until it drops. It then reads the two 32-bit halves of the shadow in either order. Because both halves come from the same edge, a carry between the halves can never give a torn value. The shadow keeps its contents until the next request completes, even though the live count keeps running.

The register port is a simple decoded strobe interface. A write takes effect on the clock edge where the write strobe is high. Read data is a combinational function of the address and the registered state, so reads have no side effects.

Top module: `latched_counter64`

## Requirements
- R1: While reset is low, and after it is released, the control word (offset 0xA0), the low snapshot word (0xA4) and the high snapshot word (0xA8) all read zero. The live count also restarts from zero, so the first snapshot taken after a reset with no enabled ticks is zero.
- R2: The live count increases by exactly one on each clock edge where the count-enable input is high. It holds its value on every other edge.
- R3: A write to offset 0xA0 with data bit 1 set raises the request flag. In the cycle after that write edge, the flag reads back as 1 at bit 1 of offset 0xA0.
- R4: The request flag clears without software action on the second clock edge after the write edge that raised it. It therefore reads 1 for exactly two polls, taken one per cycle.
- R5: When the flag clears, the snapshot holds the live count as it stood just before the clearing edge. Bits 31:0 of that value read at 0xA4 and bits 63:32 read at 0xA8.
- R6: The snapshot keeps its value while no request is pending, however many ticks the live count takes.
- R7: A request written while an earlier request is still pending merges into that request. It neither restarts nor extends the two-edge capture latency.
- R8: Writes to 0xA0 with bit 1 clear have no effect. Writes to 0xA4, 0xA8 or any other offset also have no effect.
- R9: Every bit of 0xA0 other than bit 1 reads zero, and every offset other than 0xA0, 0xA4 and 0xA8 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| tick_en | input | 1 | Count enable, high for one cycle per time-base tick |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 8 | Byte offset of the register being accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |

## Verification
Counting and capture can fall on the same clock edge: the capture edge may also carry a tick. The bench provokes this by holding the count enable high through the whole request window. It then checks that the snapshot shows the count from before that edge, and that the next snapshot sees the tick that edge added. A second overlap is a repeat request that lands while the first is still pending. The bench judges it by counting the polls until the flag drops and by comparing the snapshot with the count taken before the original clearing edge.

// File: rtl/latch_cnt_pkg.sv
package latch_cnt_pkg;
  localparam int unsigned OFS_CTRL    = 32'hA0;
  localparam int unsigned OFS_SNAP0   = 32'hA4;
  localparam int unsigned WORD_STRIDE = 4;
  localparam int unsigned REQ_BIT     = 1;
endpackage

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (tick_en) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(cnt_q));
endmodule

// File: rtl/snap_capture.sv
module snap_capture #(
  parameter int unsigned CNT_W   = 64,
  parameter int unsigned CAP_LAT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_wr,
  input  logic [CNT_W-1:0] live_cnt,
  output logic             pend_o,
  output logic [CNT_W-1:0] shadow_o
);
  localparam int unsigned DLY_W = (CAP_LAT < 2) ? 1 : $clog2(CAP_LAT + 1);

  logic             pend_q, pend_d;
  logic [DLY_W-1:0] dly_q, dly_d;
  logic [CNT_W-1:0] shd_q, shd_d;
  logic             cap_now;

  assign cap_now = pend_q && (dly_q == DLY_W'(CAP_LAT - 1));

  always_comb begin
    pend_d = pend_q;
    dly_d  = dly_q;
    shd_d  = shd_q;
    if (!pend_q) begin
      if (req_wr) begin
        pend_d = 1'b1;
        dly_d  = '0;
      end
    end else if (cap_now) begin
      pend_d = 1'b0;
      dly_d  = '0;
      shd_d  = live_cnt;
    end else begin
      dly_d = dly_q + DLY_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      dly_q  <= '0;
      shd_q  <= '0;
    end else begin
      pend_q <= pend_d;
      dly_q  <= dly_d;
      shd_q  <= shd_d;
    end
  end

  assign pend_o   = pend_q;
  assign shadow_o = shd_q;

  logic [DLY_W:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      age_q <= '0;
    else if (pend_q) age_q <= age_q + (DLY_W+1)'(1);
    else             age_q <= '0;
  end

  // R3
  req_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wr && !pend_q) |=> pend_q);
  // R4
  req_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_q) |-> (age_q == (DLY_W+1)'(CAP_LAT)));
  // R7
  req_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> (age_q < (DLY_W+1)'(CAP_LAT)));
  // R5
  shadow_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_q) |-> (shd_q == $past(live_cnt)));
  // R6
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_q |=> $stable(shd_q));
endmodule

// File: rtl/snap_read_mux.sv
module snap_read_mux
  import latch_cnt_pkg::*;
#(
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned BUS_W  = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              pend,
  input  logic [CNT_W-1:0]  shadow,
  output logic [BUS_W-1:0]  rdata
);
  localparam int unsigned N_WORDS = CNT_W / BUS_W;

  logic [N_WORDS-1:0] word_hit;

  genvar gi;
  generate
    for (gi = 0; gi < N_WORDS; gi++) begin : g_hit
      assign word_hit[gi] = (addr == ADDR_W'(OFS_SNAP0 + WORD_STRIDE * gi));
    end
  endgenerate

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(OFS_CTRL)) rdata[REQ_BIT] = pend;
    for (int i = 0; i < N_WORDS; i++) begin
      if (word_hit[i]) rdata = shadow[i*BUS_W +: BUS_W];
    end
  end

  // R9
  always_comb begin
    if (!(word_hit != '0) && addr != ADDR_W'(OFS_CTRL))
      unmapped_zero_chk: assert (rdata == '0);
  end
endmodule

// File: rtl/latched_counter64.sv
module latched_counter64
  import latch_cnt_pkg::*;
#(
  parameter int unsigned CNT_W   = 64,
  parameter int unsigned BUS_W   = 32,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned CAP_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata
);
  logic [CNT_W-1:0] live_cnt;
  logic [CNT_W-1:0] shadow;
  logic             pend;
  logic             req_wr;

  assign req_wr = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL)) && bus_wdata[REQ_BIT];

  tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .count_o (live_cnt)
  );

  snap_capture #(.CNT_W(CNT_W), .CAP_LAT(CAP_LAT)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_wr   (req_wr),
    .live_cnt (live_cnt),
    .pend_o   (pend),
    .shadow_o (shadow)
  );

  snap_read_mux #(.CNT_W(CNT_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_rd (
    .addr   (bus_addr),
    .pend   (pend),
    .shadow (shadow),
    .rdata  (bus_rdata)
  );

  // R8
  ignored_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !req_wr && !pend) |=> !pend);
endmodule

// File: tb/latched_counter64_bench.sv
module latched_counter64_bench;
  localparam logic [7:0] A_CTRL = 8'hA0;
  localparam logic [7:0] A_LO   = 8'hA4;
  localparam logic [7:0] A_HI   = 8'hA8;

  // {ticks to run, expected cumulative count}
  localparam int unsigned VEC [6][2] = '{
    '{5, 5}, '{0, 5}, '{17, 22}, '{1, 23}, '{300, 323}, '{64, 387}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;

  int checks = 0;
  int errors = 0;
  longint unsigned model = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  latched_counter64 u_latched_counter64 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic wr_cycle(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = 32'h0;
  endtask

  task automatic run_ticks(input int unsigned n);
    tick_en = 1'b1;
    for (int i = 0; i < int'(n); i++) begin
      @(negedge clk);
      model++;
    end
    tick_en = 1'b0;
  endtask

  task automatic snapshot(output int polls);
    logic [31:0] v;
    wr_cycle(A_CTRL, 32'h2);
    polls = 0;
    rd(A_CTRL, v);
    while (v[1] && polls < 20) begin
      polls++;
      @(negedge clk);
      rd(A_CTRL, v);
    end
  endtask

  initial begin
    logic [31:0] v;
    int polls;
    longint unsigned c0;
    @(negedge clk);
    // R1: values held in reset
    rd(A_CTRL, v); check("R1 ctrl in reset", v, 32'h0);
    rd(A_LO, v);   check("R1 lo in reset", v, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    rd(A_HI, v);   check("R1 hi after reset", v, 32'h0);

    // R2 R4 R5: table walk
    for (int k = 0; k < 6; k++) begin
      run_ticks(VEC[k][0]);
      snapshot(polls);
      check("R4 poll count", 32'(polls), 32'd2);
      rd(A_LO, v); check("R5 lo word", v, 32'(VEC[k][1]));
      rd(A_HI, v); check("R5 hi word", v, 32'h0);
      check("R2 model agrees", 32'(model), 32'(VEC[k][1]));
    end

    // R3: flag visible one cycle after write
    wr_cycle(A_CTRL, 32'h2);
    rd(A_CTRL, v); check("R3 flag set", v, 32'h2);
    @(negedge clk); rd(A_CTRL, v); check("R4 flag still set", v, 32'h2);
    @(negedge clk); rd(A_CTRL, v); check("R4 flag cleared", v, 32'h0);

    // R6: shadow holds while counting
    run_ticks(50);
    rd(A_LO, v); check("R6 shadow held", v, 32'(model - 50));

    // Overlap: tick on every edge of the request window, including capture edge
    c0 = model;
    tick_en = 1'b1;
    bus_wr = 1'b1; bus_addr = A_CTRL; bus_wdata = 32'h2;
    @(negedge clk); model++;
    bus_wr = 1'b0;
    @(negedge clk); model++;
    @(negedge clk); model++;
    tick_en = 1'b0;
    rd(A_CTRL, v); check("R4 flag clear with ticks", v, 32'h0);
    rd(A_LO, v);   check("R5 capture edge tick excluded", v, 32'(c0 + 2));
    snapshot(polls);
    rd(A_LO, v);   check("R2 capture edge tick counted", v, 32'(model));

    // R7: repeat request while pending
    run_ticks(3);
    wr_cycle(A_CTRL, 32'h2);
    wr_cycle(A_CTRL, 32'h2);
    rd(A_CTRL, v); check("R7 still pending", v, 32'h2);
    @(negedge clk);
    rd(A_CTRL, v); check("R7 no extension", v, 32'h0);
    rd(A_LO, v);   check("R7 sample", v, 32'(model));

    // R8: ignored writes
    wr_cycle(A_CTRL, 32'hFFFF_FFFD);
    rd(A_CTRL, v); check("R8 bit1 clear ignored", v, 32'h0);
    wr_cycle(A_LO, 32'hDEAD_BEEF);
    rd(A_LO, v);   check("R8 lo write ignored", v, 32'(model));
    wr_cycle(A_HI, 32'h1234_5678);
    rd(A_HI, v);   check("R8 hi write ignored", v, 32'h0);
    wr_cycle(8'h10, 32'h2);
    rd(A_CTRL, v); check("R8 other offset ignored", v, 32'h0);

    // R9: unmapped reads and reserved control bits
    rd(8'h10, v); check("R9 unmapped 0x10", v, 32'h0);
    rd(8'hAC, v); check("R9 unmapped 0xAC", v, 32'h0);
    wr_cycle(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, v); check("R9 reserved ctrl bits", v, 32'h2);
    @(negedge clk); @(negedge clk);

    // R1: reset mid-run clears counter and shadow
    run_ticks(9);
    rst_n = 1'b0;
    @(negedge clk);
    rd(A_LO, v); check("R1 shadow cleared", v, 32'h0);
    rst_n = 1'b1; model = 0;
    @(negedge clk);
    snapshot(polls);
    rd(A_LO, v); check("R1 counter cleared", v, 32'h0);
    rd(A_HI, v); check("R1 hi cleared", v, 32'h0);

    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule